// File: doc/BRIEF.md
# Host Data Bus Buffer for a Slave Controller

This block sits between an external host bus and the internal processor of a slave controller. The host sees an 8-bit data path, a chip select, read and write strobes, an address line that picks between data and control, and a DMA acknowledge. Inside there are two byte buffers, one for each direction, and a status byte. The status byte holds four hardware flags, and the processor writes its upper bits.

The host strobes arrive without any relation to the internal clock. They are synchronized before use. Each buffer or flag update is taken once, on the trailing (rising) edge of a strobe. A host write also records the address level. The processor can then tell a command byte (address high) from a data byte (address low).

Two options can be switched on from the processor side at run time. The first mirrors the buffer-full flags onto two interrupt pins. The second adds a request line: the processor raises it, and an acknowledged host access, which needs neither chip select nor address, lowers it again. The host bus appears as a separate input, output and output enable, and an I/O pad outside the block joins them.

Top module: `hbb_bus`

## Requirements
- R1: After reset the status byte reads 0x00, the request pin is low, and with the interrupt option off both interrupt pins are high.
- R2: A host write with chip select low stores the data byte in the input buffer, sets the input-full flag, and copies the address level into the command flag.
- R3: A host read with address high returns the status byte and changes no flag. The layout is: bit 0 output-full, bit 1 input-full, bit 2 user flag, bit 3 command flag, bits 7..4 the processor nibble.
- R4: A host read with address low returns the output buffer and clears the output-full flag.
- R5: A processor read of the input buffer clears input-full. A processor load of the output buffer sets output-full. The command flag and the user flag keep their values through both operations.
- R6: The processor can set and clear the user flag and can write the status nibble. Each change appears in the status byte.
- R7: A host write while input-full is already set overwrites the input buffer and updates the command flag again.
- R8: With the interrupt option on, one pin follows output-full and the other follows input-full, so the second pin is low while the input buffer is empty. With the option off, both pins are high.
- R9: With the DMA option on, the processor raises the request pin. A host read with DACK low and chip select high returns the output buffer, clears output-full and drops the request. While the request is high, the status shows output-full set.
- R10: With the DMA option on, a host write with DACK low loads the input buffer, sets input-full and drops the request, and it leaves the command flag unchanged.
- R11: With the DMA option off, a strobe with DACK low and chip select high changes no flag and does not enable the bus output.
- R12: The bus output enable is high only while the read strobe is low and either chip select is low or DACK is low with the DMA option on.
- R13: Each strobe causes exactly one update, however long it is held. The update appears at the third rising clock edge after the strobe returns high (two synchronizer stages).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low reset |
| host_cs_n | input | 1 | Host chip select, active low |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_a0 | input | 1 | Host address: 1 control/status, 0 data |
| host_dack_n | input | 1 | DMA acknowledge, active low |
| host_d_i | input | 8 | Host data into the block |
| host_d_o | output | 8 | Data toward the host (status or output buffer) |
| host_d_oe | output | 1 | Host bus output enable |
| cpu_obuf_ld | input | 1 | Processor loads the output buffer |
| cpu_obuf_data | input | 8 | Byte for the output buffer |
| cpu_ibuf_rd | input | 1 | Processor reads the input buffer |
| cpu_ibuf_data | output | 8 | Input buffer contents |
| cpu_ibf | output | 1 | Input-full flag |
| cpu_obf | output | 1 | Output-full flag |
| cpu_f1 | output | 1 | Command flag |
| cpu_f0_set | input | 1 | Set the user flag |
| cpu_f0_clr | input | 1 | Clear the user flag |
| cpu_nib_wr | input | 1 | Write the status nibble |
| cpu_nib_data | input | 4 | New status nibble |
| cpu_irq_en | input | 1 | Interrupt pin option enable |
| cpu_dma_en | input | 1 | DMA option enable |
| cpu_drq_set | input | 1 | Raise the DMA request |
| pin_obf | output | 1 | Output-full interrupt pin |
| pin_ibf | output | 1 | Input-full interrupt pin |
| pin_drq | output | 1 | DMA request pin |

## Verification
Read data and the output enable follow the host pins combinationally, so the bench samples them while the read strobe is held low. Flag and buffer changes from a host strobe are due at the third rising edge after the strobe goes high. The bench therefore waits four falling edges after each strobe before it reads status or processor outputs. In the latency test, the input-full flag is checked to still be low at the first and second falling edges after release and to be high at the third. Processor-side operations take effect at the next rising edge, and the bench checks them one falling edge after the pulse.

// File: rtl/hbb_pkg.sv
package hbb_pkg;

   typedef struct packed {
      logic cs_n;
      logic rd_n;
      logic wr_n;
      logic a0;
      logic dack_n;
   } hbb_ctl_t;

   localparam hbb_ctl_t HBB_CTL_IDLE = '{cs_n: 1'b1, rd_n: 1'b1, wr_n: 1'b1,
                                        a0: 1'b1, dack_n: 1'b1};

   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_PIO  = 2'd1,
      SEL_DMA  = 2'd2
   } hbb_sel_e;

   localparam int ST_OBF = 0;
   localparam int ST_IBF = 1;
   localparam int ST_F0  = 2;
   localparam int ST_F1  = 3;

endpackage

// File: rtl/hbb_sync.sv
module hbb_sync
   import hbb_pkg::*;
#(
   parameter int DW     = 8,
   parameter int STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  hbb_ctl_t      ctl_i,
   input  logic [DW-1:0] data_i,
   input  logic          dma_en,
   output logic          wr_ev,
   output logic          rd_ev,
   output hbb_sel_e      sel,
   output logic          a0,
   output logic [DW-1:0] wdata
);

   localparam int DEPTH = STAGES + 1;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("hbb_sync: STAGES must be at least 2");
      end
   endgenerate

   hbb_ctl_t      ctl_p [DEPTH];
   logic [DW-1:0] dat_p [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_p[0] <= HBB_CTL_IDLE;
         dat_p[0] <= '0;
      end else begin
         ctl_p[0] <= ctl_i;
         dat_p[0] <= data_i;
      end
   end

   generate
      for (genvar s = 1; s < DEPTH; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ctl_p[s] <= HBB_CTL_IDLE;
               dat_p[s] <= '0;
            end else begin
               ctl_p[s] <= ctl_p[s-1];
               dat_p[s] <= dat_p[s-1];
            end
         end
      end
   endgenerate

   hbb_ctl_t last, nxt;
   assign last = ctl_p[DEPTH-1];
   assign nxt  = ctl_p[DEPTH-2];

   always_comb begin
      if (dma_en && !last.dack_n) sel = SEL_DMA;
      else if (!last.cs_n)        sel = SEL_PIO;
      else                        sel = SEL_NONE;
   end

   assign wr_ev = !last.wr_n && nxt.wr_n && (sel != SEL_NONE);
   assign rd_ev = !last.rd_n && nxt.rd_n && (sel != SEL_NONE);
   assign a0    = last.a0;
   assign wdata = dat_p[DEPTH-1];

   AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ev |=> !wr_ev);                                      // R13
   AST_RD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_ev |=> !rd_ev);                                      // R13

endmodule

// File: rtl/hbb_core.sv
module hbb_core
   import hbb_pkg::*;
#(
   parameter int DW    = 8,
   parameter int NIB_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_ev,
   input  logic             rd_ev,
   input  hbb_sel_e         sel,
   input  logic             a0,
   input  logic [DW-1:0]    wdata,
   input  logic             obuf_ld,
   input  logic [DW-1:0]    obuf_din,
   input  logic             ibuf_rd,
   input  logic             f0_set,
   input  logic             f0_clr,
   input  logic             nib_wr,
   input  logic [NIB_W-1:0] nib_din,
   input  logic             dma_en,
   input  logic             drq_set,
   output logic [DW-1:0]    ibuf,
   output logic [DW-1:0]    obuf,
   output logic             ibf,
   output logic             obf,
   output logic             f0,
   output logic             f1,
   output logic [NIB_W-1:0] nib,
   output logic             drq
);

   logic pio_wr, dma_acc, out_taken;
   assign pio_wr    = wr_ev && (sel == SEL_PIO);
   assign dma_acc   = (wr_ev || rd_ev) && (sel == SEL_DMA);
   assign out_taken = rd_ev && ((sel == SEL_DMA) || !a0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ibuf <= '0;
         obuf <= '0;
         ibf  <= 1'b0;
         obf  <= 1'b0;
         f0   <= 1'b0;
         f1   <= 1'b0;
         nib  <= '0;
         drq  <= 1'b0;
      end else begin
         if (wr_ev)        ibuf <= wdata;
         if (wr_ev)        ibf  <= 1'b1;
         else if (ibuf_rd) ibf  <= 1'b0;
         if (pio_wr)       f1   <= a0;
         if (obuf_ld)      obuf <= obuf_din;
         if (obuf_ld)        obf <= 1'b1;
         else if (out_taken) obf <= 1'b0;
         if (f0_set)       f0   <= 1'b1;
         else if (f0_clr)  f0   <= 1'b0;
         if (nib_wr)       nib  <= nib_din;
         if (!dma_en)      drq  <= 1'b0;
         else if (drq_set) drq  <= 1'b1;
         else if (dma_acc) drq  <= 1'b0;
      end
   end

   AST_IBF_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ev |=> ibf);                                          // R2
   AST_F1_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_ev && sel == SEL_PIO) |=> $stable(f1));             // R5
   AST_OBF_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_ev && sel == SEL_DMA && !obuf_ld) |=> !obf);         // R9
   AST_DRQ_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      ((wr_ev || rd_ev) && sel == SEL_DMA && !drq_set) |=> !drq); // R10
   AST_NIB_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !nib_wr |=> $stable(nib));                               // R6

endmodule

// File: rtl/hbb_bus.sv
module hbb_bus
   import hbb_pkg::*;
#(
   parameter int DW          = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit HAS_IRQ     = 1'b1,
   parameter bit HAS_DMA     = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          host_cs_n,
   input  logic          host_rd_n,
   input  logic          host_wr_n,
   input  logic          host_a0,
   input  logic          host_dack_n,
   input  logic [DW-1:0] host_d_i,
   output logic [DW-1:0] host_d_o,
   output logic          host_d_oe,
   input  logic          cpu_obuf_ld,
   input  logic [DW-1:0] cpu_obuf_data,
   input  logic          cpu_ibuf_rd,
   output logic [DW-1:0] cpu_ibuf_data,
   output logic          cpu_ibf,
   output logic          cpu_obf,
   output logic          cpu_f1,
   input  logic          cpu_f0_set,
   input  logic          cpu_f0_clr,
   input  logic          cpu_nib_wr,
   input  logic [DW-5:0] cpu_nib_data,
   input  logic          cpu_irq_en,
   input  logic          cpu_dma_en,
   input  logic          cpu_drq_set,
   output logic          pin_obf,
   output logic          pin_ibf,
   output logic          pin_drq
);

   localparam int NIB_W = DW - 4;

   generate
      if (DW < 5) begin : g_bad_width
         $error("hbb_bus: DW must leave room for a status nibble");
      end
   endgenerate

   logic dma_on;
   assign dma_on = HAS_DMA && cpu_dma_en;

   hbb_ctl_t ctl_raw;
   assign ctl_raw = '{cs_n: host_cs_n, rd_n: host_rd_n, wr_n: host_wr_n,
                      a0: host_a0, dack_n: host_dack_n};

   logic          wr_ev, rd_ev, ev_a0;
   hbb_sel_e      ev_sel;
   logic [DW-1:0] ev_data;

   hbb_sync #(.DW(DW), .STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .ctl_i  (ctl_raw),
      .data_i (host_d_i),
      .dma_en (dma_on),
      .wr_ev  (wr_ev),
      .rd_ev  (rd_ev),
      .sel    (ev_sel),
      .a0     (ev_a0),
      .wdata  (ev_data)
   );

   logic [DW-1:0]    ibuf, obuf;
   logic             ibf, obf, f0, f1, drq;
   logic [NIB_W-1:0] nib;

   hbb_core #(.DW(DW), .NIB_W(NIB_W)) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_ev    (wr_ev),
      .rd_ev    (rd_ev),
      .sel      (ev_sel),
      .a0       (ev_a0),
      .wdata    (ev_data),
      .obuf_ld  (cpu_obuf_ld),
      .obuf_din (cpu_obuf_data),
      .ibuf_rd  (cpu_ibuf_rd),
      .f0_set   (cpu_f0_set),
      .f0_clr   (cpu_f0_clr),
      .nib_wr   (cpu_nib_wr),
      .nib_din  (cpu_nib_data),
      .dma_en   (dma_on),
      .drq_set  (cpu_drq_set),
      .ibuf     (ibuf),
      .obuf     (obuf),
      .ibf      (ibf),
      .obf      (obf),
      .f0       (f0),
      .f1       (f1),
      .nib      (nib),
      .drq      (drq)
   );

   logic [DW-1:0] status;
   always_comb begin
      status         = '0;
      status[ST_OBF] = obf;
      status[ST_IBF] = ibf;
      status[ST_F0]  = f0;
      status[ST_F1]  = f1;
      status[DW-1:4] = nib;
   end

   logic dack_sel;
   assign dack_sel  = dma_on && !host_dack_n;
   assign host_d_oe = !host_rd_n && (!host_cs_n || dack_sel);
   assign host_d_o  = (dack_sel || !host_a0) ? obuf : status;

   assign cpu_ibuf_data = ibuf;
   assign cpu_ibf       = ibf;
   assign cpu_obf       = obf;
   assign cpu_f1        = f1;

   generate
      if (HAS_IRQ) begin : g_irq
         assign pin_obf = cpu_irq_en ? obf : 1'b1;
         assign pin_ibf = cpu_irq_en ? ibf : 1'b1;
      end else begin : g_no_irq
         assign pin_obf = 1'b1;
         assign pin_ibf = 1'b1;
      end
      if (HAS_DMA) begin : g_dma
         assign pin_drq = drq;
      end else begin : g_no_dma
         assign pin_drq = 1'b0;
      end
   endgenerate

   AST_OE_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
      host_d_oe |-> !host_rd_n);                               // R12
   AST_NO_DRQ_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_dma_en |=> !pin_drq);                               // R11

endmodule

// File: tb/tb_hbb_bus.sv
module tb_hbb_bus;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       host_cs_n = 1'b1, host_rd_n = 1'b1, host_wr_n = 1'b1;
   logic       host_a0 = 1'b0, host_dack_n = 1'b1;
   logic [7:0] host_d_i = '0;
   logic [7:0] host_d_o;
   logic       host_d_oe;
   logic       cpu_obuf_ld = 1'b0;
   logic [7:0] cpu_obuf_data = '0;
   logic       cpu_ibuf_rd = 1'b0;
   logic [7:0] cpu_ibuf_data;
   logic       cpu_ibf, cpu_obf, cpu_f1;
   logic       cpu_f0_set = 1'b0, cpu_f0_clr = 1'b0, cpu_nib_wr = 1'b0;
   logic [3:0] cpu_nib_data = '0;
   logic       cpu_irq_en = 1'b0, cpu_dma_en = 1'b0, cpu_drq_set = 1'b0;
   logic       pin_obf, pin_ibf, pin_drq;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   hbb_bus dut (
      .clk(clk), .rst_n(rst_n),
      .host_cs_n(host_cs_n), .host_rd_n(host_rd_n), .host_wr_n(host_wr_n),
      .host_a0(host_a0), .host_dack_n(host_dack_n),
      .host_d_i(host_d_i), .host_d_o(host_d_o), .host_d_oe(host_d_oe),
      .cpu_obuf_ld(cpu_obuf_ld), .cpu_obuf_data(cpu_obuf_data),
      .cpu_ibuf_rd(cpu_ibuf_rd), .cpu_ibuf_data(cpu_ibuf_data),
      .cpu_ibf(cpu_ibf), .cpu_obf(cpu_obf), .cpu_f1(cpu_f1),
      .cpu_f0_set(cpu_f0_set), .cpu_f0_clr(cpu_f0_clr),
      .cpu_nib_wr(cpu_nib_wr), .cpu_nib_data(cpu_nib_data),
      .cpu_irq_en(cpu_irq_en), .cpu_dma_en(cpu_dma_en),
      .cpu_drq_set(cpu_drq_set),
      .pin_obf(pin_obf), .pin_ibf(pin_ibf), .pin_drq(pin_drq)
   );

   task automatic chk(input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic host_write(input bit use_dack, input logic a0,
                             input logic [7:0] d);
      @(negedge clk);
      host_cs_n = use_dack; host_dack_n = !use_dack;
      host_a0 = a0; host_d_i = d;
      repeat (2) @(negedge clk);
      host_wr_n = 1'b0;
      repeat (3) @(negedge clk);
      host_wr_n = 1'b1;
      repeat (4) @(negedge clk);
      host_cs_n = 1'b1; host_dack_n = 1'b1;
      repeat (2) @(negedge clk);
   endtask

   task automatic host_read(input bit use_dack, input logic a0,
                            output logic [7:0] q, output logic oe);
      @(negedge clk);
      host_cs_n = use_dack; host_dack_n = !use_dack; host_a0 = a0;
      repeat (2) @(negedge clk);
      host_rd_n = 1'b0;
      repeat (3) @(negedge clk);
      q = host_d_o; oe = host_d_oe;
      host_rd_n = 1'b1;
      repeat (4) @(negedge clk);
      host_cs_n = 1'b1; host_dack_n = 1'b1;
      repeat (2) @(negedge clk);
   endtask

   task automatic status_is(input string req, input logic [7:0] exp);
      logic [7:0] q;
      logic oe;
      host_read(1'b0, 1'b1, q, oe);
      chk(req, {24'd0, q}, {24'd0, exp});
   endtask

   task automatic cpu_read();
      @(negedge clk); cpu_ibuf_rd = 1'b1;
      @(negedge clk); cpu_ibuf_rd = 1'b0;
   endtask

   task automatic cpu_load(input logic [7:0] d);
      @(negedge clk); cpu_obuf_ld = 1'b1; cpu_obuf_data = d;
      @(negedge clk); cpu_obuf_ld = 1'b0;
   endtask

   task automatic drq_raise();
      @(negedge clk); cpu_drq_set = 1'b1;
      @(negedge clk); cpu_drq_set = 1'b0;
   endtask

   task automatic t_reset();
      logic [7:0] q;
      logic oe;
      chk("R1 drq after reset", {31'd0, pin_drq}, 32'd0);
      chk("R1 pins idle", {30'd0, pin_obf, pin_ibf}, 32'd3);
      chk("R12 oe idle", {31'd0, host_d_oe}, 32'd0);
      host_read(1'b0, 1'b1, q, oe);
      chk("R1 status after reset", {24'd0, q}, 32'h00);
      chk("R12 oe on status read", {31'd0, oe}, 32'd1);
      chk("R12 oe released", {31'd0, host_d_oe}, 32'd0);
   endtask

   task automatic t_write();
      host_write(1'b0, 1'b1, 8'h5A);
      chk("R2 ibuf", {24'd0, cpu_ibuf_data}, 32'h5A);
      status_is("R2 R3 status after command write", 8'h0A);
      status_is("R3 status read changes nothing", 8'h0A);
      host_write(1'b0, 1'b0, 8'h33);
      chk("R7 overwrite data", {24'd0, cpu_ibuf_data}, 32'h33);
      status_is("R7 command flag rewritten", 8'h02);
   endtask

   task automatic t_cpu();
      logic [7:0] q;
      logic oe;
      cpu_read();
      status_is("R5 ibf cleared by cpu read", 8'h00);
      host_write(1'b0, 1'b1, 8'h01);
      cpu_read();
      status_is("R5 f1 kept through cpu read", 8'h08);
      @(negedge clk); cpu_f0_set = 1'b1;
      @(negedge clk); cpu_f0_set = 1'b0; cpu_nib_wr = 1'b1; cpu_nib_data = 4'hA;
      @(negedge clk); cpu_nib_wr = 1'b0;
      status_is("R6 f0 and nibble", 8'hAC);
      cpu_load(8'h99);
      status_is("R5 obf set by cpu load", 8'hAD);
      host_read(1'b0, 1'b0, q, oe);
      chk("R4 data read", {24'd0, q}, 32'h99);
      status_is("R4 obf cleared by data read", 8'hAC);
      @(negedge clk); cpu_f0_clr = 1'b1;
      @(negedge clk); cpu_f0_clr = 1'b0;
      status_is("R6 f0 cleared", 8'hA8);
   endtask

   task automatic t_irq();
      logic [7:0] q;
      logic oe;
      @(negedge clk); cpu_irq_en = 1'b1;
      @(negedge clk);
      chk("R8 pins empty", {30'd0, pin_obf, pin_ibf}, 32'd0);
      host_write(1'b0, 1'b0, 8'h11);
      chk("R8 ibf pin high", {31'd0, pin_ibf}, 32'd1);
      cpu_load(8'h42);
      chk("R8 obf pin high", {31'd0, pin_obf}, 32'd1);
      host_read(1'b0, 1'b0, q, oe);
      chk("R8 obf pin low after read", {31'd0, pin_obf}, 32'd0);
      cpu_read();
      chk("R8 ibf pin low after cpu read", {31'd0, pin_ibf}, 32'd0);
      @(negedge clk); cpu_irq_en = 1'b0;
      @(negedge clk);
      chk("R8 pins high when disabled", {30'd0, pin_obf, pin_ibf}, 32'd3);
   endtask

   task automatic t_dma();
      logic [7:0] q;
      logic oe;
      host_read(1'b1, 1'b0, q, oe);
      chk("R11 no oe without dma", {31'd0, oe}, 32'd0);
      cpu_load(8'h01);
      host_read(1'b1, 1'b0, q, oe);
      chk("R11 obf kept without dma", {31'd0, cpu_obf}, 32'd1);
      host_write(1'b1, 1'b0, 8'h77);
      chk("R11 ibf kept without dma", {31'd0, cpu_ibf}, 32'd0);
      @(negedge clk); cpu_dma_en = 1'b1;
      drq_raise();
      chk("R9 drq raised", {31'd0, pin_drq}, 32'd1);
      status_is("R9 status during request", 8'hA1);
      chk("R9 drq held over status read", {31'd0, pin_drq}, 32'd1);
      host_read(1'b1, 1'b0, q, oe);
      chk("R9 dma read data", {24'd0, q}, 32'h01);
      chk("R9 dma read oe", {31'd0, oe}, 32'd1);
      chk("R9 drq dropped", {31'd0, pin_drq}, 32'd0);
      status_is("R9 obf cleared by dma read", 8'hA0);
      host_write(1'b0, 1'b1, 8'h22);
      cpu_read();
      drq_raise();
      host_write(1'b1, 1'b0, 8'h04);
      chk("R10 dma write data", {24'd0, cpu_ibuf_data}, 32'h04);
      chk("R10 ibf set", {31'd0, cpu_ibf}, 32'd1);
      chk("R10 drq dropped", {31'd0, pin_drq}, 32'd0);
      chk("R10 f1 unchanged", {31'd0, cpu_f1}, 32'd1);
      cpu_read();
      @(negedge clk); cpu_dma_en = 1'b0;
   endtask

   task automatic t_latency();
      @(negedge clk);
      host_cs_n = 1'b0; host_a0 = 1'b0; host_d_i = 8'h5C;
      repeat (2) @(negedge clk);
      host_wr_n = 1'b0;
      repeat (12) @(negedge clk);
      chk("R13 no update while held", {31'd0, cpu_ibf}, 32'd0);
      host_wr_n = 1'b1;
      @(negedge clk);
      chk("R13 not yet after one edge", {31'd0, cpu_ibf}, 32'd0);
      @(negedge clk);
      chk("R13 not yet after two edges", {31'd0, cpu_ibf}, 32'd0);
      @(negedge clk);
      chk("R13 update at third edge", {31'd0, cpu_ibf}, 32'd1);
      repeat (2) @(negedge clk);
      host_cs_n = 1'b1;
      cpu_read();
      repeat (10) @(negedge clk);
      chk("R13 single update per strobe", {31'd0, cpu_ibf}, 32'd0);
      chk("R13 data latched", {24'd0, cpu_ibuf_data}, 32'h5C);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_write();
      t_cpu();
      t_irq();
      t_dma();
      t_latency();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule